// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple synchronous host port and a 4-bit-wide asynchronous DRAM with a multiplexed address bus. Each host request carries a 22-bit word address. The upper 11 bits select a row and the lower 11 bits select a column. The controller turns each request into a sequence of row strobe, column strobe, write enable and output enable transitions. It counts every timing limit in clock cycles.

After an access the row stays open. A later request to the same row then costs only a column cycle. A request to another row first precharges the open row and then opens the new one. A free-running timer asks for a CAS-before-RAS refresh at a fixed interval. A pending refresh takes priority over new host requests and closes any open page. After reset the controller waits for a startup period and performs a burst of refresh cycles. Only then does it accept host traffic. Every write uses early-write ordering: write enable falls before the column strobe, so the shared data pins never see two drivers.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and during the startup wait, the RAS, CAS, WE and OE strobes are all high (inactive) and `req_ready` is low. Exactly `INIT_REFS` refresh cycles (8 by default) complete before `req_ready` first rises.
- R2: For an access, `dram_addr` carries request address bits [21:11] when RAS falls and bits [10:0] when CAS falls.
- R3: On a write, WE is low at least one clock before CAS falls, and WE never falls while CAS is low.
- R4: The controller drives `dram_dq` only while WE is low and OE is high. OE is low only during a read column cycle, with WE high and both RAS and CAS low.
- R5: A read returns, on `rd_data`, the value most recently written to that address, together with a `rd_valid` pulse that lasts one clock.
- R6: A read that hits the open row produces no RAS transition. Its `rd_valid` pulse appears in the clock cycle that starts `T_CAC`+1 rising edges after the accepting edge.
- R7: A read issued while a different row is open pays `T_RP`+`T_RCD` extra cycles over a hit. A read issued with no row open pays `T_RCD`+1 extra cycles. RAS stays high for at least `T_RP` cycles before every falling edge.
- R8: A refresh takes CAS low one or more cycles before RAS falls, with WE high. Refreshes recur once per `REF_INTERVAL` clocks whether or not the host is idle.
- R9: A pending refresh holds `req_ready` low. A row left open by earlier accesses is closed by the refresh, so the next access opens its row again.
- R10: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a column cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq | inout | 4 | Shared data pins |

## Verification
Read latency is fixed once a request is accepted. The bench starts counting at the accepting rising edge and samples `rd_valid` on falling edges. It expects the pulse at the falling edge numbered `T_CAC`+2 for an open-row hit, `T_RP`+`T_RCD`+`T_CAC`+2 when another row is open, and `T_RCD`+`T_CAC`+3 after a refresh has closed the page. A behavioural memory model checks the strobes on falling edges, when the registered strobes have settled. Each falling RAS or CAS edge is therefore checked half a cycle after it leaves the controller. The model counts refreshes to check the startup burst and the refresh rate over idle windows.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    ST_INIT,    // startup wait, all strobes high
    ST_IDLE,    // precharged, no row open
    ST_PRE,     // RAS high, row address on pins
    ST_ACT,     // RAS low, RAS-to-CAS delay
    ST_COLSET,  // column address set up, WE settles
    ST_CAS,     // CAS low
    ST_OPEN,    // row open, waiting for traffic
    ST_PREREF,  // closing page before refresh
    ST_REFCAS,  // CAS low ahead of RAS
    ST_REFRAS,  // CAS and RAS low
    ST_REFPRE   // refresh precharge
  } edo_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= TW'(INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      cnt <= tick ? TW'(INTERVAL - 1) : cnt - 1'b1;
      if (tick)
        pending <= 1'b1;
      else if (ack)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (open_i) begin
      valid_q <= 1'b1;
      row_q   <= row_i;
    end else if (close_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (probe_row == row_q);
endmodule

// File: rtl/edo_strobe_fsm.sv
module edo_strobe_fsm
  import edo_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int T_RCD     = 4,
  parameter int T_CAC     = 2,
  parameter int T_RP      = 5,
  parameter int T_RAS     = 6,
  parameter int T_INIT    = 10000,
  parameter int INIT_REFS = 8,
  localparam int PIN_W    = imax(ROW_W, COL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             ref_pending,
  input  logic             page_hit,
  output logic             req_ready,
  output logic             accept,
  output logic             ref_ack,
  output logic             row_open,
  output logic             row_close,
  output logic [ROW_W-1:0] open_row,
  output logic             capture,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_drive,
  output logic [PIN_W-1:0] addr
);
  localparam int DMAX  = imax(imax(imax(T_INIT, T_RP), imax(T_RCD, T_CAC)), T_RAS);
  localparam int CNT_W = $clog2(DMAX + 1);
  localparam int IR_W  = $clog2(INIT_REFS + 1);

  edo_state_e       state, nxt;
  logic [CNT_W-1:0] cnt, dur;
  logic [IR_W-1:0]  init_left;
  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n;
  logic             wr_q, wr_n, done, col_phase;

  assign done      = (cnt == '0);
  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pending;
  assign accept    = req_ready && req_valid;
  assign row_n     = accept ? req_row : row_q;
  assign col_n     = accept ? req_col : col_q;
  assign wr_n      = accept ? req_write : wr_q;
  assign open_row  = row_q;

  always_comb begin
    nxt = state;
    dur = CNT_W'(1);
    unique case (state)
      ST_INIT:   if (done) nxt = ST_REFCAS;
      ST_IDLE: begin
        if (ref_pending)    nxt = ST_REFCAS;
        else if (req_valid) nxt = ST_PRE;
      end
      ST_OPEN: begin
        if (ref_pending) begin
          nxt = ST_PREREF; dur = CNT_W'(T_RP);
        end else if (req_valid) begin
          if (page_hit) nxt = ST_COLSET;
          else begin nxt = ST_PRE; dur = CNT_W'(T_RP); end
        end
      end
      ST_PRE:    if (done) begin nxt = ST_ACT; dur = CNT_W'(T_RCD); end
      ST_ACT:    if (done) nxt = ST_COLSET;
      ST_COLSET: if (done) begin nxt = ST_CAS; dur = CNT_W'(T_CAC); end
      ST_CAS:    if (done) nxt = ST_OPEN;
      ST_PREREF: if (done) nxt = ST_REFCAS;
      ST_REFCAS: if (done) begin nxt = ST_REFRAS; dur = CNT_W'(T_RAS); end
      ST_REFRAS: if (done) begin nxt = ST_REFPRE; dur = CNT_W'(T_RP); end
      ST_REFPRE: if (done) nxt = (init_left != '0) ? ST_REFCAS : ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign ref_ack   = (nxt == ST_REFCAS) && (state != ST_REFCAS);
  assign row_open  = (nxt == ST_ACT) && (state != ST_ACT);
  assign row_close = (nxt == ST_PRE) || (nxt == ST_PREREF);
  assign capture   = (state == ST_CAS) && done && !wr_q;
  assign col_phase = (nxt == ST_COLSET) || (nxt == ST_CAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      cnt       <= CNT_W'(T_INIT - 1);
      init_left <= IR_W'(INIT_REFS);
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_drive  <= 1'b0;
      addr      <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= dur - 1'b1;
      else if (!done)   cnt <= cnt - 1'b1;
      if (ref_ack && (init_left != '0)) init_left <= init_left - 1'b1;
      if (accept) begin
        row_q <= req_row;
        col_q <= req_col;
        wr_q  <= req_write;
      end
      ras_n    <= !(nxt inside {ST_ACT, ST_COLSET, ST_CAS, ST_OPEN, ST_REFRAS});
      cas_n    <= !(nxt inside {ST_CAS, ST_REFCAS, ST_REFRAS});
      we_n     <= !(col_phase && wr_n);
      oe_n     <= !((nxt == ST_CAS) && !wr_n);
      dq_drive <= col_phase && wr_n;
      if ((nxt == ST_PRE) || (nxt == ST_ACT)) addr <= PIN_W'(row_n);
      else if (col_phase)                     addr <= PIN_W'(col_n);
    end
  end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int T_RCD        = 4,
  parameter int T_CAC        = 2,
  parameter int T_RP         = 5,
  parameter int T_RAS        = 6,
  parameter int T_INIT       = 10000,
  parameter int REF_INTERVAL = 1560,
  parameter int INIT_REFS    = 8,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int PIN_W       = imax(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [PIN_W-1:0]  dram_addr,
  inout  wire  [DATA_W-1:0] dram_dq
);
  logic             ref_pending, ref_ack, page_hit, row_open, row_close;
  logic             accept, capture, dq_drive;
  logic [ROW_W-1:0] open_row;
  logic [DATA_W-1:0] wdata_q;

  edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending)
  );

  edo_page_tracker #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst(rst), .open_i(row_open), .close_i(row_close),
    .row_i(open_row), .probe_row(req_addr[ADDR_W-1:COL_W]), .hit(page_hit)
  );

  edo_strobe_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_INIT(T_INIT), .INIT_REFS(INIT_REFS)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_addr[ADDR_W-1:COL_W]), .req_col(req_addr[COL_W-1:0]),
    .ref_pending(ref_pending), .page_hit(page_hit), .req_ready(req_ready),
    .accept(accept), .ref_ack(ref_ack), .row_open(row_open),
    .row_close(row_close), .open_row(open_row), .capture(capture),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .oe_n(dram_oe_n), .dq_drive(dq_drive), .addr(dram_addr)
  );

  assign dram_dq = dq_drive ? wdata_q : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (accept)  wdata_q <= req_wdata;
      if (capture) rd_data <= dram_dq;
      rd_valid <= capture;
    end
  end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int T_RP = 5
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_drive,
  input logic rd_valid,
  input logic req_ready
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 hi_cnt <= '0;
    else if (!ras_n)         hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
  end

  // R3
  we_fall_cas_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> cas_n);
  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |-> !$past(we_n));
  // R4
  drive_no_contend_chk: assert property (@(posedge clk) disable iff (rst)
    dq_drive |-> (oe_n && !we_n));
  // R4
  oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !cas_n && !ras_n));
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R7
  precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (int'(hi_cnt) >= T_RP));
  // R8
  cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> (we_n && !$past(cas_n)));
  // R10
  ready_idle_cas_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cas_n);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.T_RP(T_RP)) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_drive(dq_drive),
  .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
  localparam int T_RCD = 4, T_CAC = 2, T_RP = 5, T_RAS = 6;
  localparam int T_INIT = 40, REF_INTERVAL = 400, INIT_REFS = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n;
  logic [3:0]  rd_data;
  logic [10:0] dram_addr;
  wire  [3:0]  dram_dq;

  int checks = 0, errors = 0;
  int ref_cnt = 0, ref_at_last = -1;
  logic [21:0] last_addr = '0;
  logic [10:0] open_row = '0;
  logic [10:0] m_row = '0, m_col = '0;
  logic [3:0]  mdl_q = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [3:0] m_mem [int];
  logic [3:0] e_mem [int];

  always #2 clk = ~clk;

  edo_dram_ctrl #(
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RP(T_RP), .T_RAS(T_RAS), .T_INIT(T_INIT),
    .REF_INTERVAL(REF_INTERVAL), .INIT_REFS(INIT_REFS)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dram_addr), .dram_dq(dram_dq)
  );

  assign dram_dq = (!oe_n && !cas_n && !ras_n && we_n) ? mdl_q : 4'bz;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] rd_exp(input logic [21:0] a);
    return e_mem.exists(int'(a)) ? e_mem[int'(a)] : 4'h0;
  endfunction

  // memory model, evaluated after strobes settle
  always @(negedge clk) begin
    if (!rst) begin
      if (p_ras && !ras_n) begin
        if (!cas_n) begin
          ref_cnt++;
          chk(we_n, "R8 refresh WE high", int'(we_n), 1);
        end else begin
          m_row = dram_addr;
          chk(dram_addr == last_addr[21:11], "R2 row address", int'(dram_addr), int'(last_addr[21:11]));
        end
      end
      if (p_cas && !cas_n && !ras_n) begin
        m_col = dram_addr;
        chk(dram_addr == last_addr[10:0], "R2 column address", int'(dram_addr), int'(last_addr[10:0]));
        if (!we_n) begin
          chk(!p_we && oe_n, "R3 early write", int'(p_we), 0);
          m_mem[int'({m_row, m_col})] = dram_dq;
        end else begin
          mdl_q = m_mem.exists(int'({m_row, m_col})) ? m_mem[int'({m_row, m_col})] : 4'h0;
        end
      end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  task automatic do_op(input bit wr, input logic [21:0] a, input logic [3:0] d);
    int n, exp_n;
    bit closed;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    closed = (ref_cnt != ref_at_last);
    if (closed)                     exp_n = T_RCD + T_CAC + 3;
    else if (a[21:11] == open_row)  exp_n = T_CAC + 2;
    else                            exp_n = T_RP + T_RCD + T_CAC + 2;
    last_addr = a;
    ref_at_last = ref_cnt;
    open_row = a[21:11];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (wr) begin
      e_mem[int'(a)] = d;
      chk(!req_ready, "R10 busy after accept", int'(req_ready), 0);
    end else begin
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      if (closed)                  chk(n == exp_n, "R9 latency after refresh", n, exp_n);
      else if (exp_n == T_CAC + 2) chk(n == exp_n, "R6 page hit latency", n, exp_n);
      else                         chk(n == exp_n, "R7 page miss latency", n, exp_n);
      chk(rd_data == rd_exp(a), "R5 read data", int'(rd_data), int'(rd_exp(a)));
      @(negedge clk);
      chk(!rd_valid, "R5 single pulse", int'(rd_valid), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 150000 expected less");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, w;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF && !req_ready, "R1 reset strobes", int'({ras_n, cas_n, we_n, oe_n}), 15);
    rst = 1'b0;
    repeat (T_INIT / 2) @(negedge clk);
    chk({ras_n, cas_n} == 2'b11 && ref_cnt == 0, "R1 startup wait idle", ref_cnt, 0);
    w = 0;
    while (!req_ready && w < 5000) begin @(negedge clk); w++; end
    chk(ref_cnt == INIT_REFS, "R1 startup refresh count", ref_cnt, INIT_REFS);

    // directed corner cases
    do_op(1'b1, {11'h005, 11'h010}, 4'h5);
    do_op(1'b0, {11'h005, 11'h010}, 4'h0);
    do_op(1'b1, {11'h005, 11'h7FF}, 4'hA);
    do_op(1'b0, {11'h005, 11'h7FF}, 4'h0);
    do_op(1'b0, {11'h7FF, 11'h000}, 4'h0);
    do_op(1'b0, {11'h005, 11'h010}, 4'h0);
    // idle long enough for a refresh to close the page
    r0 = ref_cnt;
    repeat (2000) @(negedge clk);
    w = ref_cnt - r0;
    chk(w >= 4 && w <= 6, "R8 refresh rate", w, 5);
    do_op(1'b0, {11'h005, 11'h7FF}, 4'h0);

    // constrained random traffic over a few rows
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      logic [10:0] row;
      case ($urandom_range(3))
        0: row = 11'h000;
        1: row = 11'h001;
        2: row = 11'h2AA;
        default: row = 11'h7FF;
      endcase
      do_op(1'($urandom_range(1)), {row, 11'($urandom_range(15))}, 4'($urandom));
      if ($urandom_range(7) == 0) repeat ($urandom_range(60)) @(negedge clk);
    end
    chk(ref_cnt > INIT_REFS + 5, "R8 refresh under traffic", ref_cnt, INIT_REFS + 6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule